// File: doc/BRIEF.md
# Bus transfer sizer and lane steerer

This block sits between a core-side load/store request port and an external 32-bit big-endian data bus. A request carries an address, a transfer size, a read/write flag and right-justified write data. It also carries the port width of the addressed region and a flag that marks regions run by the internal memory controller. The block first checks natural alignment. A misaligned request is refused at once. An aligned request is turned into one or more external bus cycles, each moving as many bytes as the port width permits.

Narrow ports (16 or 8 bits) sit on the most-significant lanes of the bus. A word or half-word aimed at a narrow port is therefore split into sequential cycles. Each cycle advances the byte offset and steers the next operand bytes onto the top lanes. On reads, the bytes returned by each cycle are collected and handed back right-justified with a single completion pulse. Every external cycle waits for the bus acknowledge, and no new request is taken until the whole operation has finished.

Top module: `bus_sizer`

## Requirements
- R1: A half-word request with address bit 0 set, or a word/burst-beat request (size 2 or 3) with either of address bits 1:0 set, is misaligned. It raises `rsp_err` for exactly one cycle, in the cycle after acceptance, and drives no bus cycle. A byte request is never misaligned.
- R2: A byte request (size 0) at offset k to a 32-bit port takes one cycle. It enables only lane k (OP0 is `bus_lane_en[3]` on data bits 31:24, OP3 is `bus_lane_en[0]` on bits 7:0) and carries the byte in that lane.
- R3: A half-word request (size 1) to a 32-bit port takes one cycle. It uses lanes OP0/OP1 when address bit 1 is 0 and lanes OP2/OP3 when it is 1, with the more significant byte on the lower-numbered lane.
- R4: Port code 1 (16-bit) enables only lanes OP0/OP1. Port code 2 (8-bit) enables only lane OP0. Port code 0 (32-bit) may use all four lanes.
- R5: When `rgn_int` is 0, or the port code is 3, the region is handled as a 32-bit port whatever the port code says.
- R6: The first cycle of a word write presents the whole operand on `bus_wdata`, with OP0 through OP3 in their natural lanes, for every port width.
- R7: Every cycle moves min(operand bytes, port bytes). A word request takes 2 cycles to a 16-bit port, at offsets 0 and 2, and 4 cycles to an 8-bit port, at offsets 0 to 3. A half-word request takes 2 cycles to an 8-bit port. `bus_addr` carries the request's upper bits and the current byte offset.
- R8: A bus cycle completes only on an edge where `bus_ack` is high. While it is held off, `bus_req`, `bus_addr`, `bus_lane_en` and `bus_wdata` stay unchanged.
- R9: A read returns the operand right-justified on `rsp_rdata`, with the byte at the lowest address most significant. This happens in a one-cycle `rsp_done` pulse in the cycle after the last acknowledge. Writes also end with that pulse.
- R10: `req_ready` is high only when idle. It stays low from acceptance through the `rsp_done` or `rsp_err` cycle.
- R11: A burst-beat request (size 3) is handled exactly like a word request.
- R12: After reset, `req_ready` is high and `bus_req`, `rsp_done` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 burst beat |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Right-justified write operand |
| rgn_port | input | 2 | Region port width: 0 32-bit, 1 16-bit, 2 8-bit, 3 treated as 32-bit |
| rgn_int | input | 1 | Region run by the internal memory controller |
| rsp_done | output | 1 | Operation complete pulse |
| rsp_err | output | 1 | Misalignment error pulse |
| rsp_rdata | output | 32 | Right-justified read result, valid with rsp_done |
| bus_req | output | 1 | External cycle active |
| bus_addr | output | AW | Address of the current cycle |
| bus_we | output | 1 | Direction of the current cycle |
| bus_lane_en | output | 4 | Byte lane enables, bit 3 is OP0 (bits 31:24) |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the bus |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
The bench builds the block with a 12-bit address, four lanes and narrow ports enabled. In this configuration every combination of port code, internal-controller flag, transfer size, byte offset and direction is reachable: 256 operations in all. Each one is compared against byte-level arithmetic on a small bus memory model. Acknowledges are delayed by zero to two cycles in a rotating pattern. This exercises stalled beats, split transfers on both narrow widths, the word-first-cycle rule, and every misaligned offset.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BEAT = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      PW_32  = 2'd0,
      PW_16  = 2'd1,
      PW_8   = 2'd2,
      PW_RSV = 2'd3
   } port_w_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUS  = 2'd1,
      ST_ERR  = 2'd2,
      ST_DONE = 2'd3
   } seq_st_e;

   // natural alignment rule
   function automatic logic misaligned(input xfer_size_e s, input logic [1:0] o);
      case (s)
         SZ_BYTE: return 1'b0;
         SZ_HALF: return o[0];
         default: return (o != 2'd0);
      endcase
   endfunction

endpackage

// File: rtl/bsz_plan.sv
module bsz_plan
   import bsz_pkg::*;
(
   input  xfer_size_e size,
   input  logic [1:0] base_off,
   input  port_w_e    pw,
   output logic [2:0] n_bytes,
   output logic [2:0] beat_bytes,
   output logic [1:0] last_beat,
   output logic [1:0] lane_mask,
   output logic [2:0] res_shift
);

   logic [2:0] port_bytes;

   always_comb begin
      case (size)
         SZ_BYTE: n_bytes = 3'd1;
         SZ_HALF: n_bytes = 3'd2;
         default: n_bytes = 3'd4;
      endcase
      case (pw)
         PW_16:   begin port_bytes = 3'd2; lane_mask = 2'b01; end
         PW_8:    begin port_bytes = 3'd1; lane_mask = 2'b00; end
         default: begin port_bytes = 3'd4; lane_mask = 2'b11; end
      endcase
      beat_bytes = (n_bytes < port_bytes) ? n_bytes : port_bytes;
      // beats - 1 = n / per-beat - 1
      case ({n_bytes, beat_bytes})
         {3'd4, 3'd1}: last_beat = 2'd3;
         {3'd4, 3'd2}: last_beat = 2'd1;
         {3'd2, 3'd1}: last_beat = 2'd1;
         default:      last_beat = 2'd0;
      endcase
      // distance from the operand's last lane to lane OP3
      res_shift = 3'd4 - n_bytes - {1'b0, base_off};
   end

endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer #(
   parameter int LANES = 4,
   localparam int DW = 8 * LANES
) (
   input  logic [DW-1:0]    wdata,
   input  logic [2:0]       n_bytes,
   input  logic [2:0]       res_shift,
   input  logic [1:0]       beat_shift,
   input  logic [1:0]       lane_first,
   input  logic [2:0]       beat_bytes,
   output logic [DW-1:0]    bus_wdata,
   output logic [LANES-1:0] lane_en
);

   logic [DW-1:0] ones;
   logic [DW-1:0] op_mask;
   logic [DW-1:0] nat;
   logic [2:0]    gap;
   logic [2:0]    lane_end;

   assign ones     = '1;
   assign gap      = 3'(LANES) - n_bytes;
   assign op_mask  = ones >> {gap, 3'b000};
   // operand placed at its address lanes of a full-width word
   assign nat      = (wdata & op_mask) << {res_shift, 3'b000};
   // port lanes start at the top of the bus
   assign bus_wdata = nat << {beat_shift, 3'b000};
   assign lane_end = {1'b0, lane_first} + beat_bytes;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_en[LANES-1-l] = (3'(l) >= {1'b0, lane_first}) && (3'(l) < lane_end);
   end

endmodule

// File: rtl/bsz_rd_gather.sv
module bsz_rd_gather #(
   parameter int LANES = 4,
   localparam int DW = 8 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cap,
   input  logic [DW-1:0]    bus_rdata,
   input  logic [LANES-1:0] lane_en,
   input  logic [1:0]       beat_shift,
   input  logic [2:0]       res_shift,
   input  logic [2:0]       n_bytes,
   output logic [DW-1:0]    result
);

   logic [DW-1:0] hold_q;
   logic [DW-1:0] lane_bits;
   logic [DW-1:0] ones;
   logic [DW-1:0] op_mask;
   logic [2:0]    gap;

   for (genvar l = 0; l < LANES; l++) begin : g_bits
      assign lane_bits[8*l +: 8] = {8{lane_en[l]}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (clr) begin
         hold_q <= '0;
      end else if (cap) begin
         hold_q <= hold_q | ((bus_rdata & lane_bits) >> {beat_shift, 3'b000});
      end
   end

   assign ones    = '1;
   assign gap     = 3'(LANES) - n_bytes;
   assign op_mask = ones >> {gap, 3'b000};
   assign result  = (hold_q >> {res_shift, 3'b000}) & op_mask;

endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
   import bsz_pkg::*;
#(
   parameter int AW = 26,
   parameter int LANES = 4,
   parameter bit ALLOW_NARROW = 1'b1,
   localparam int DW = 8 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [AW-1:0]    req_addr,
   input  logic [1:0]       req_size,
   input  logic             req_we,
   input  logic [DW-1:0]    req_wdata,
   input  logic [1:0]       rgn_port,
   input  logic             rgn_int,
   output logic             rsp_done,
   output logic             rsp_err,
   output logic [DW-1:0]    rsp_rdata,
   output logic             bus_req,
   output logic [AW-1:0]    bus_addr,
   output logic             bus_we,
   output logic [LANES-1:0] bus_lane_en,
   output logic [DW-1:0]    bus_wdata,
   input  logic [DW-1:0]    bus_rdata,
   input  logic             bus_ack
);

   if (LANES != 4) begin : g_bad_lanes
      $error("bus_sizer: LANES must be 4");
   end
   if (AW < 3) begin : g_bad_aw
      $error("bus_sizer: AW must be at least 3");
   end

   seq_st_e    st_q;
   logic [AW-3:0] hi_q;
   logic [1:0] off_q;
   xfer_size_e size_q;
   logic       we_q;
   logic [DW-1:0] wdata_q;
   port_w_e    pw_q;
   port_w_e    pw_in;
   logic [1:0] beat_cnt_q;
   logic [1:0] beat_off_q;

   logic [2:0] n_bytes;
   logic [2:0] beat_bytes;
   logic [1:0] last_beat;
   logic [1:0] lane_mask;
   logic [2:0] res_shift;
   logic [1:0] beat_shift;
   logic [1:0] lane_first;
   logic       accept;
   logic       beat_fin;

   if (ALLOW_NARROW) begin : g_narrow
      assign pw_in = (rgn_int && rgn_port != 2'd3) ? port_w_e'(rgn_port) : PW_32;
   end else begin : g_wide
      assign pw_in = PW_32;
   end

   assign accept   = (st_q == ST_IDLE) && req_valid;
   assign beat_fin = (st_q == ST_BUS) && bus_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         hi_q       <= '0;
         off_q      <= '0;
         size_q     <= SZ_BYTE;
         we_q       <= 1'b0;
         wdata_q    <= '0;
         pw_q       <= PW_32;
         beat_cnt_q <= '0;
         beat_off_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  hi_q       <= req_addr[AW-1:2];
                  off_q      <= req_addr[1:0];
                  size_q     <= xfer_size_e'(req_size);
                  we_q       <= req_we;
                  wdata_q    <= req_wdata;
                  pw_q       <= pw_in;
                  beat_cnt_q <= '0;
                  beat_off_q <= req_addr[1:0];
                  st_q       <= misaligned(xfer_size_e'(req_size), req_addr[1:0])
                                ? ST_ERR : ST_BUS;
               end
            end
            ST_BUS: begin
               if (bus_ack) begin
                  if (beat_cnt_q == last_beat) begin
                     st_q <= ST_DONE;
                  end else begin
                     beat_cnt_q <= beat_cnt_q + 2'd1;
                     beat_off_q <= beat_off_q + beat_bytes[1:0];
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   bsz_plan i_plan (
      .size      (size_q),
      .base_off  (off_q),
      .pw        (pw_q),
      .n_bytes   (n_bytes),
      .beat_bytes(beat_bytes),
      .last_beat (last_beat),
      .lane_mask (lane_mask),
      .res_shift (res_shift)
   );

   assign beat_shift = beat_off_q & ~lane_mask;
   assign lane_first = beat_off_q & lane_mask;

   bsz_wr_steer #(.LANES(LANES)) i_wr (
      .wdata     (wdata_q),
      .n_bytes   (n_bytes),
      .res_shift (res_shift),
      .beat_shift(beat_shift),
      .lane_first(lane_first),
      .beat_bytes(beat_bytes),
      .bus_wdata (bus_wdata),
      .lane_en   (bus_lane_en)
   );

   bsz_rd_gather #(.LANES(LANES)) i_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .cap       (beat_fin && !we_q),
      .bus_rdata (bus_rdata),
      .lane_en   (bus_lane_en),
      .beat_shift(beat_shift),
      .res_shift (res_shift),
      .n_bytes   (n_bytes),
      .result    (rsp_rdata)
   );

   assign req_ready = (st_q == ST_IDLE);
   assign rsp_done  = (st_q == ST_DONE);
   assign rsp_err   = (st_q == ST_ERR);
   assign bus_req   = (st_q == ST_BUS);
   assign bus_we    = we_q;
   assign bus_addr  = {hi_q, beat_off_q};

endmodule

// File: rtl/bsz_chk.sv
module bsz_chk
   import bsz_pkg::*;
#(
   parameter int AW = 26,
   parameter int LANES = 4,
   localparam int DW = 8 * LANES
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_done,
   input logic             rsp_err,
   input logic             bus_req,
   input logic             bus_ack,
   input logic [AW-1:0]    bus_addr,
   input logic [LANES-1:0] bus_lane_en,
   input logic [DW-1:0]    bus_wdata,
   input port_w_e          pw_q
);

   // R1: an error response never overlaps a bus cycle or a completion
   a_r1_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!bus_req && !rsp_done));

   // R1: the error lasts one cycle
   a_r1_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |=> !rsp_err);

   // R4: a 16-bit port never sees the lower two lanes
   a_r4_port16_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && pw_q == PW_16) |-> (bus_lane_en[1:0] == 2'b00));

   // R4: an 8-bit port only sees the top lane
   a_r4_port8_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && pw_q == PW_8) |-> (bus_lane_en[2:0] == 3'b000));

   // R7: every cycle moves at least one byte
   a_r7_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> ($countones(bus_lane_en) != 0));

   // R8: a cycle held off by the acknowledge keeps its outputs
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                 && $stable(bus_lane_en) && $stable(bus_wdata)));

   // R9: one completion pulse, only right after an acknowledged cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(bus_req && bus_ack));

   // R10: no request taken while an operation is in flight
   a_r10_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req || rsp_done || rsp_err) |-> !req_ready);

endmodule

bind bus_sizer bsz_chk #(.AW(AW), .LANES(LANES)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_done   (rsp_done),
   .rsp_err    (rsp_err),
   .bus_req    (bus_req),
   .bus_ack    (bus_ack),
   .bus_addr   (bus_addr),
   .bus_lane_en(bus_lane_en),
   .bus_wdata  (bus_wdata),
   .pw_q       (pw_q)
);

// File: tb/test_bus_sizer.sv
module test_bus_sizer;
   import bsz_pkg::*;

   localparam int AW = 12;

   logic          clk;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [AW-1:0] req_addr;
   logic [1:0]    req_size;
   logic          req_we;
   logic [31:0]   req_wdata;
   logic [1:0]    rgn_port;
   logic          rgn_int;
   logic          rsp_done;
   logic          rsp_err;
   logic [31:0]   rsp_rdata;
   logic          bus_req;
   logic [AW-1:0] bus_addr;
   logic          bus_we;
   logic [3:0]    bus_lane_en;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic          bus_ack;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   bus_sizer #(.AW(AW)) i_bus_sizer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_we(req_we),
      .req_wdata(req_wdata), .rgn_port(rgn_port), .rgn_int(rgn_int),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_lane_en(bus_lane_en), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] memb(input int x, input int id);
      return 8'((8'h5A ^ (x * 29)) ^ id);
   endfunction

   task automatic run_op(input int pw_sel, input bit intc, input int sz,
                         input int off, input bit we, input int id);
      int n;
      int epw;
      int pb;
      int bb;
      int nbeats;
      int beats;
      int wcnt;
      int seen_bus;
      int errs;
      int dones;
      int o;
      int first;
      bit mis;
      string tag;
      logic [AW-1:0] addr;
      logic [31:0] wd;
      logic [31:0] got;
      logic [31:0] expv;
      logic [3:0]  e_en;
      logic [7:0]  wmem [4];
      bit          wrote [4];
      bit          ok;

      n      = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      epw    = (intc && pw_sel != 3) ? pw_sel : 0;
      pb     = (epw == 0) ? 4 : (epw == 1) ? 2 : 1;
      bb     = (n < pb) ? n : pb;
      nbeats = n / bb;
      mis    = (sz == 1 && off[0]) || (sz >= 2 && off != 0);
      tag    = mis ? "R1" : (!intc && pw_sel != 0) ? "R5" :
               (sz == 0) ? "R2" : (sz == 1) ? "R3" : (sz == 3) ? "R11" : "R7";
      addr   = AW'((id + 5) * 4 + off);
      wd     = 32'(id * 32'h9E3779B1) ^ 32'h13572468;
      beats = 0; wcnt = id % 3; seen_bus = 0; errs = 0; dones = 0; got = '0;
      for (int i = 0; i < 4; i++) begin wmem[i] = 8'h00; wrote[i] = 1'b0; end

      chk(req_ready, "R10", "ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_addr = addr; req_size = 2'(sz); req_we = we;
      req_wdata = wd; rgn_port = 2'(pw_sel); rgn_int = intc;
      @(negedge clk);
      req_valid = 1'b0;

      for (int cyc = 0; cyc < 64; cyc++) begin
         if (cyc == 0)
            chk(!req_ready, "R10", "ready low after accept", 32'(req_ready), 32'd0);
         if (rsp_err) begin errs++; break; end
         if (rsp_done) begin dones++; got = rsp_rdata; break; end
         if (bus_req) begin
            seen_bus++;
            if (wcnt > 0) begin
               bus_ack = 1'b0;
               wcnt--;
            end else begin
               o = off + beats * bb;
               first = o & (pb - 1);
               e_en = 4'b0000;
               for (int j = first; j < first + bb; j++) e_en[3-j] = 1'b1;
               chk(bus_addr == AW'((id + 5) * 4 + o), tag, "beat address",
                   32'(bus_addr), 32'((id + 5) * 4 + o));
               chk(bus_lane_en == e_en, (pw_sel != 0) ? "R4" : tag, "lane enables",
                   32'(bus_lane_en), 32'(e_en));
               chk(bus_we == we, tag, "direction", 32'(bus_we), 32'(we));
               if (we && n == 4 && beats == 0)
                  chk(bus_wdata == wd, "R6", "first word cycle data", bus_wdata, wd);
               for (int j = 0; j < 4; j++) begin
                  if (bus_lane_en[3-j]) begin
                     wmem[o - first + j]  = bus_wdata[31-8*j -: 8];
                     wrote[o - first + j] = 1'b1;
                  end
                  bus_rdata[31-8*j -: 8] = (j < pb) ? memb(o - first + j, id) : 8'hEE;
               end
               bus_ack = 1'b1;
               beats++;
               wcnt = (id + beats) % 3;
            end
         end else begin
            bus_ack = 1'b0;
         end
         @(negedge clk);
      end
      bus_ack = 1'b0;

      if (mis) begin
         chk(errs == 1 && seen_bus == 0, "R1", "error without bus cycle",
             32'(errs * 16 + seen_bus), 32'h10);
      end else begin
         chk(errs == 0 && dones == 1, "R9", "completion pulse seen",
             32'(errs * 16 + dones), 32'h01);
         chk(beats == nbeats, (pw_sel != 0 && intc) ? "R7" : tag, "beat count",
             32'(beats), 32'(nbeats));
         if (we) begin
            ok = 1'b1;
            for (int m = 0; m < 4; m++) begin
               if (m >= off && m < off + n) begin
                  if (!wrote[m] || wmem[m] != wd[8*(n-1-(m-off)) +: 8]) ok = 1'b0;
               end else if (wrote[m]) begin
                  ok = 1'b0;
               end
            end
            chk(ok, tag, "written bytes", {wmem[0], wmem[1], wmem[2], wmem[3]}, wd);
         end else begin
            expv = '0;
            for (int m = 0; m < n; m++) expv = (expv << 8) | 32'(memb(off + m, id));
            chk(got == expv, (sz == 0 || sz == 1) ? tag : "R9", "read result", got, expv);
         end
      end
      @(negedge clk);
      chk(req_ready && !rsp_done && !rsp_err, "R10", "idle after response",
          {29'd0, req_ready, rsp_done, rsp_err}, 32'h4);
   endtask

   initial begin
      int id;
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_we = 1'b0;
      req_wdata = '0; rgn_port = '0; rgn_int = 1'b0; bus_rdata = '0; bus_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !bus_req && !rsp_done && !rsp_err, "R12", "reset state",
          {28'd0, req_ready, bus_req, rsp_done, rsp_err}, 32'h8);
      id = 0;
      for (int p = 0; p < 4; p++)
         for (int ic = 0; ic < 2; ic++)
            for (int s = 0; s < 4; s++)
               for (int of = 0; of < 4; of++)
                  for (int w = 0; w < 2; w++) begin
                     run_op(p, ic[0], s, of, w[0], id);
                     id++;
                  end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule